// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block sits between a processor load/store port and a slower word-wide memory port. It keeps four block frames. Each frame holds a valid flag, a modified flag, an address tag and a block of four 32-bit words. Every memory block can live in exactly one frame, chosen by two index bits of its address. A lookup reads the indexed frame and compares tags. A hit is served from the frame. A miss brings the whole block in from memory, one word per memory handshake. If the frame being replaced holds modified data, that data is written out to memory first.

Stores on a hit change only the cached copy and mark the frame modified. Memory stays stale until that frame is evicted or a flush is run. A store miss first fetches the block, then merges the bytes selected by the byte enables. A flush request sweeps all frames and writes each valid modified frame back to memory. The swept frames stay valid and become clean. Two counters record how many accepted requests hit and how many missed.

The processor request channel is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the request fields steady. `req_ready` is low during every writeback, refill and flush. Every accepted request produces exactly one `rsp_valid` pulse, and the processor must always take it. The memory channel holds `mem_req_valid` and its fields steady until `mem_ack` is seen. On a read, `mem_rdata` is taken in the cycle where `mem_ack` is high.

Top module: `wb_dcache`

## Requirements
- R1: After reset every frame is invalid, `hit_cnt` and `miss_cnt` are zero, `req_ready` is high and no memory request is raised. The first access to any frame is a miss.
- R2: A byte address splits as tag = bits [15:6], frame index = bits [5:4], word in block = bits [3:2] and byte in word = bits [1:0]. Memory addresses issued by the block use the same layout.
- R3: A lookup hits only if the indexed frame is valid and its tag equals the address tag. A load hit raises `rsp_valid` in the cycle after acceptance with the cached word, and causes no memory traffic.
- R4: On a miss, the block makes four memory reads at the block base address plus 0, 4, 8 and 12, in that order. It installs the block with the new tag, then completes the access.
- R5: A store hit writes only the bytes whose `req_be` bit is set (bit n covers data bits 8n+7..8n). It marks the frame modified and makes no memory write.
- R6: A store miss refills the block first, then merges the enabled store bytes into the refilled word and marks the frame modified.
- R7: A miss to a valid, modified frame first writes its four words to memory at the address rebuilt from the stored tag, in rising word order. Only then does it start the refill reads.
- R8: A miss to an invalid or clean frame makes no memory write.
- R9: A pulse on `flush_start` while idle sweeps frames 0 to 3. It writes the four words of each valid modified frame in rising order and holds `flush_busy` high until the sweep ends. Afterwards every frame keeps its valid state and is clean.
- R10: Each accepted request increments exactly one of `hit_cnt` and `miss_cnt` by one.
- R11: `req_ready` is low whenever a memory request is pending or a flush is running. A memory request keeps its address, direction and write data steady until acknowledged.
- R12: `rsp_valid` is a single-cycle pulse, one per accepted request, and a load's pulse carries the requested word on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| flush_start | input | 1 | Start a writeback sweep (sampled while idle) |
| flush_busy | output | 1 | Sweep in progress |
| mem_req_valid | output | 1 | Memory word request pending |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory byte address of the word |
| mem_wdata | output | 32 | Word written to memory |
| mem_ack | input | 1 | Memory completes the pending word |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| hit_cnt | output | 16 | Accepted requests that hit |
| miss_cnt | output | 16 | Accepted requests that missed |

## Verification
The access sweep runs a load to every frame after reset, which must miss cleanly. It then loads every word of every frame, which must all hit, and stores with a different byte-enable pattern on each word, which tells correct byte merging apart from whole-word writes. Conflicting tags are then aimed at modified frames and at clean frames. The traffic logs tell an evict-then-refill sequence apart from a bare refill, and show that the writeback address comes from the stored tag rather than the new one. A store miss checks that merging happens after the refill. Two flushes, one with modified frames and one with none, are followed by re-accesses and evictions. These show that swept frames stay valid and clean, and that main memory then matches the bench's coherent model word for word.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_DONE,
    ST_FSCAN,
    ST_FEVICT
  } dc_state_e;
endpackage

// File: rtl/dc_frames.sv
module dc_frames #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int FRAMES = 4,
  parameter int TAG_W  = 10,
  localparam int BE_W   = DATA_W / 8,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mark_dirty,
  input  logic              inst_en,
  input  logic [IDX_W-1:0]  inst_idx,
  input  logic [TAG_W-1:0]  inst_tag,
  input  logic              clean_en,
  input  logic [IDX_W-1:0]  clean_idx
);
  logic [FRAMES-1:0] valid_q;
  logic [FRAMES-1:0] dirty_q;
  logic [TAG_W-1:0]  tag_q  [FRAMES];
  logic [DATA_W-1:0] data_q [FRAMES][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inst_en) begin
        valid_q[inst_idx] <= 1'b1;
        dirty_q[inst_idx] <= 1'b0;
      end
      if (clean_en) dirty_q[clean_idx] <= 1'b0;
      if (wr_en && wr_mark_dirty) dirty_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_idx] <= inst_tag;
  end

  // byte lanes of the data array
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b])
        data_q[wr_idx][wr_word][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx][rd_word];
endmodule

// File: rtl/dc_counter.sv
module dc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int FRAMES = 4,
  localparam int BE_W     = DATA_W / 8,
  localparam int BYTE_OFF = $clog2(BE_W),
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int IDX_W    = $clog2(FRAMES),
  localparam int TAG_W    = ADDR_W - IDX_W - WSEL_W - BYTE_OFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_we,
  input  logic [ADDR_W-1:BYTE_OFF]   req_waddr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [BE_W-1:0]            req_be,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic                       flush_start,
  output logic                       flush_busy,
  output logic                       mem_req_valid,
  output logic                       mem_req_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic                       mem_ack,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [IDX_W-1:0]           rd_idx,
  output logic [WSEL_W-1:0]          rd_word,
  input  logic                       rd_valid,
  input  logic                       rd_dirty,
  input  logic [TAG_W-1:0]           rd_tag,
  input  logic [DATA_W-1:0]          rd_data,
  output logic                       wr_en,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [WSEL_W-1:0]          wr_word,
  output logic [BE_W-1:0]            wr_be,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       wr_mark_dirty,
  output logic                       inst_en,
  output logic [IDX_W-1:0]           inst_idx,
  output logic [TAG_W-1:0]           inst_tag,
  output logic                       clean_en,
  output logic [IDX_W-1:0]           clean_idx,
  output logic                       hit_pulse,
  output logic                       miss_pulse
);
  localparam int LO = BYTE_OFF;
  localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_F = IDX_W'(FRAMES - 1);

  dc_state_e state;
  logic [TAG_W-1:0]  lat_tag;
  logic [IDX_W-1:0]  lat_idx;
  logic [WSEL_W-1:0] lat_word;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wdata;
  logic [BE_W-1:0]   lat_be;
  logic [WSEL_W-1:0] wcnt;
  logic [IDX_W-1:0]  fidx;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic accept, hit, in_evict, last_word;

  assign req_word = req_waddr[LO +: WSEL_W];
  assign req_idx  = req_waddr[LO + WSEL_W +: IDX_W];
  assign req_tag  = req_waddr[ADDR_W-1 -: TAG_W];

  assign req_ready = (state == ST_IDLE) && !flush_start;
  assign accept    = req_valid && req_ready;
  assign hit       = rd_valid && (rd_tag == req_tag);
  assign hit_pulse  = accept && hit;
  assign miss_pulse = accept && !hit;
  assign in_evict  = (state == ST_EVICT) || (state == ST_FEVICT);
  assign last_word = (wcnt == LAST_W);
  assign flush_busy = (state == ST_FSCAN) || (state == ST_FEVICT);

  always_comb begin
    unique case (state)
      ST_IDLE:             rd_idx = req_idx;
      ST_FSCAN, ST_FEVICT: rd_idx = fidx;
      default:             rd_idx = lat_idx;
    endcase
    if (state == ST_IDLE) rd_word = req_word;
    else if (in_evict)    rd_word = wcnt;
    else                  rd_word = lat_word;
  end

  // memory side: one word per handshake, rising word order
  assign mem_req_valid = in_evict || (state == ST_FILL);
  assign mem_req_we    = in_evict;
  assign mem_wdata     = rd_data;
  always_comb begin
    if (in_evict) mem_addr = {rd_tag, rd_idx, wcnt, {BYTE_OFF{1'b0}}};
    else          mem_addr = {lat_tag, lat_idx, wcnt, {BYTE_OFF{1'b0}}};
  end

  always_comb begin
    wr_en         = 1'b0;
    wr_idx        = rd_idx;
    wr_word       = rd_word;
    wr_be         = '1;
    wr_data       = mem_rdata;
    wr_mark_dirty = 1'b0;
    unique case (state)
      ST_IDLE: if (accept && hit && req_we) begin
        wr_en = 1'b1; wr_be = req_be; wr_data = req_wdata; wr_mark_dirty = 1'b1;
      end
      ST_FILL: if (mem_ack) begin
        wr_en = 1'b1; wr_word = wcnt;
      end
      ST_DONE: if (lat_we) begin
        wr_en = 1'b1; wr_be = lat_be; wr_data = lat_wdata; wr_mark_dirty = 1'b1;
      end
      default: ;
    endcase
  end

  assign inst_en   = (state == ST_FILL) && mem_ack && last_word;
  assign inst_idx  = lat_idx;
  assign inst_tag  = lat_tag;
  assign clean_en  = (state == ST_FEVICT) && mem_ack && last_word;
  assign clean_idx = fidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wcnt      <= '0;
      fidx      <= '0;
      lat_tag   <= '0;
      lat_idx   <= '0;
      lat_word  <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (flush_start) begin
            fidx  <= '0;
            state <= ST_FSCAN;
          end else if (accept) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= rd_data;
            end else begin
              lat_tag   <= req_tag;
              lat_idx   <= req_idx;
              lat_word  <= req_word;
              lat_we    <= req_we;
              lat_wdata <= req_wdata;
              lat_be    <= req_be;
              wcnt      <= '0;
              state     <= (rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
            end
          end
        end
        ST_EVICT: if (mem_ack) begin
          wcnt <= wcnt + 1'b1;
          if (last_word) state <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          wcnt <= wcnt + 1'b1;
          if (last_word) state <= ST_DONE;
        end
        ST_DONE: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= rd_data;
          state     <= ST_IDLE;
        end
        ST_FSCAN: begin
          if (rd_valid && rd_dirty) begin
            wcnt  <= '0;
            state <= ST_FEVICT;
          end else if (fidx == LAST_F) begin
            state <= ST_IDLE;
          end else begin
            fidx <= fidx + 1'b1;
          end
        end
        ST_FEVICT: if (mem_ack) begin
          wcnt <= wcnt + 1'b1;
          if (last_word) begin
            if (fidx == LAST_F) state <= ST_IDLE;
            else begin
              fidx  <= fidx + 1'b1;
              state <= ST_FSCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int FRAMES = 4,
  parameter int CNT_W  = 16,
  localparam int BE_W     = DATA_W / 8,
  localparam int BYTE_OFF = $clog2(BE_W),
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int IDX_W    = $clog2(FRAMES),
  localparam int TAG_W    = ADDR_W - IDX_W - WSEL_W - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flush_start,
  output logic              flush_busy,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);
  logic [IDX_W-1:0]  rd_idx, wr_idx, inst_idx, clean_idx;
  logic [WSEL_W-1:0] rd_word, wr_word;
  logic              rd_valid, rd_dirty, wr_en, wr_mark_dirty, inst_en, clean_en;
  logic [TAG_W-1:0]  rd_tag, inst_tag;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [BE_W-1:0]   wr_be;
  logic [1:0]        stat_inc;
  logic [CNT_W-1:0]  stat_cnt [2];

  dc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .FRAMES(FRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_waddr(req_addr[ADDR_W-1:BYTE_OFF]), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .flush_start(flush_start), .flush_busy(flush_busy),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_be(wr_be),
    .wr_data(wr_data), .wr_mark_dirty(wr_mark_dirty),
    .inst_en(inst_en), .inst_idx(inst_idx), .inst_tag(inst_tag),
    .clean_en(clean_en), .clean_idx(clean_idx),
    .hit_pulse(stat_inc[0]), .miss_pulse(stat_inc[1])
  );

  dc_frames #(.DATA_W(DATA_W), .WORDS(WORDS), .FRAMES(FRAMES), .TAG_W(TAG_W)) u_frames (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_be(wr_be),
    .wr_data(wr_data), .wr_mark_dirty(wr_mark_dirty),
    .inst_en(inst_en), .inst_idx(inst_idx), .inst_tag(inst_tag),
    .clean_en(clean_en), .clean_idx(clean_idx)
  );

  // index 0 counts hits, index 1 counts misses
  for (genvar g = 0; g < 2; g++) begin : g_stat
    dc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(stat_inc[g]), .count(stat_cnt[g])
    );
  end

  assign hit_cnt  = stat_cnt[0];
  assign miss_cnt = stat_cnt[1];
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W/8-1:0] req_be,
  input logic              flush_busy,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_cnt,
  input logic [CNT_W-1:0]  miss_cnt
);
  logic [CNT_W-1:0] total;
  assign total = hit_cnt + miss_cnt;

  p_stall_on_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_addr)
      && $stable(mem_req_we) && $stable(mem_wdata)));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we)
      && $stable(req_wdata) && $stable(req_be)));

  p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (total == CNT_W'($past(total) + 1'b1)));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(total));
endmodule

bind wb_dcache dc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
  .flush_busy(flush_busy), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/sim_wb_dcache.sv
module sim_wb_dcache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, flush_start = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rsp_valid, flush_busy, mem_req_valid, mem_req_we;
  logic [31:0] rsp_rdata, mem_wdata;
  logic [15:0] mem_addr, hit_cnt, miss_cnt;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wb_dcache u0 (.*);

  int n_cmp = 0, n_bad = 0;
  logic [31:0] bmem [1024];
  logic [31:0] refm [1024];
  logic [15:0] wlog [64];
  logic [15:0] rlog [64];
  int n_wr = 0, n_rd = 0;
  logic       ev [4];
  logic       ed [4];
  logic [9:0] et [4];
  int exp_hits = 0, exp_miss = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  // memory model: one word per handshake, ack raised for one cycle
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req_valid) begin
      if (mem_req_we) begin
        bmem[mem_addr[11:2]] = mem_wdata;
        if (n_wr < 64) wlog[n_wr] = mem_addr;
        n_wr++;
      end else begin
        mem_rdata = bmem[mem_addr[11:2]];
        if (n_rd < 64) rlog[n_rd] = mem_addr;
        n_rd++;
      end
      mem_ack = 1'b1;
    end
  end

  function automatic logic [15:0] mk_addr(input int tag, input int idx, input int w);
    return 16'((tag << 6) | (idx << 4) | (w << 2));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic do_op(input logic we, input int tag, input int idx, input int w,
                       input logic [31:0] data, input logic [3:0] be);
    logic [15:0] a;
    logic        exp_hit, exp_wb;
    int          old_tag, lat, bad_ready;
    a = mk_addr(tag, idx, w);
    exp_hit = ev[idx] && (et[idx] == 10'(tag));
    exp_wb  = !exp_hit && ev[idx] && ed[idx];
    old_tag = int'(et[idx]);
    n_wr = 0; n_rd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = data; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; bad_ready = 0;
    while (!rsp_valid && lat < 1000) begin
      if (mem_req_valid && req_ready) bad_ready = 1;
      lat++;
      @(negedge clk);
    end
    chk("R11 ready low during memory traffic", 32'(bad_ready), 32'd0);
    if (!we) chk("R12 load data", rsp_rdata, refm[a[11:2]]);
    if (exp_hit) begin
      exp_hits++;
      chk("R3 hit latency", 32'(lat), 32'd0);
      chk("R3 no reads on hit", 32'(n_rd), 32'd0);
      if (we) chk("R5 no write on store hit", 32'(n_wr), 32'd0);
    end else begin
      exp_miss++;
      chk("R4 refill read count", 32'(n_rd), 32'd4);
      for (int k = 0; k < 4; k++)
        chk("R2 refill address order", 32'(rlog[k]), 32'(mk_addr(tag, idx, k)));
      if (exp_wb) begin
        chk("R7 writeback count", 32'(n_wr), 32'd4);
        for (int k = 0; k < 4; k++)
          chk("R7 writeback address", 32'(wlog[k]), 32'(mk_addr(old_tag, idx, k)));
        for (int k = 0; k < 4; k++)
          chk("R7 written data", bmem[mk_addr(old_tag, idx, k) >> 2],
              refm[mk_addr(old_tag, idx, k) >> 2]);
      end else begin
        chk("R8 no write on clean miss", 32'(n_wr), 32'd0);
      end
      ev[idx] = 1'b1; et[idx] = 10'(tag); ed[idx] = 1'b0;
    end
    if (we) begin
      refm[a[11:2]] = merge(refm[a[11:2]], data, be);
      ed[idx] = 1'b1;
    end
    @(negedge clk);
    chk("R12 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_flush();
    int nd, k, lat;
    nd = 0; k = 0;
    for (int f = 0; f < 4; f++) if (ev[f] && ed[f]) nd++;
    n_wr = 0; n_rd = 0;
    @(negedge clk);
    flush_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_start = 1'b0;
    lat = 0;
    while (flush_busy && lat < 1000) begin
      if (req_ready) lat = 5000;
      lat++;
      @(negedge clk);
    end
    chk("R9 stall while flushing", 32'(lat < 1000), 32'd1);
    chk("R9 flush write count", 32'(n_wr), 32'(4 * nd));
    chk("R9 no reads in flush", 32'(n_rd), 32'd0);
    for (int f = 0; f < 4; f++) begin
      if (ev[f] && ed[f]) begin
        for (int w = 0; w < 4; w++)
          chk("R9 flush address order", 32'(wlog[k*4+w]), 32'(mk_addr(int'(et[f]), f, w)));
        k++;
      end
      ed[f] = 1'b0;
    end
    k = 0;
    for (int i = 0; i < 1024; i++) if (bmem[i] !== refm[i]) k++;
    chk("R9 memory coherent after flush", 32'(k), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0001_0003);
      refm[i] = bmem[i];
    end
    for (int f = 0; f < 4; f++) begin ev[f] = 1'b0; ed[f] = 1'b0; et[f] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 hit count reset", 32'(hit_cnt), 32'd0);
    chk("R1 miss count reset", 32'(miss_cnt), 32'd0);
    chk("R1 no memory request", 32'(mem_req_valid), 32'd0);

    // R1 first touch misses in every frame
    for (int f = 0; f < 4; f++) do_op(1'b0, 1, f, f, '0, '0);
    chk("R1 misses after first touch", 32'(miss_cnt), 32'd4);
    // R3 all words hit
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 4; w++) do_op(1'b0, 1, f, w, '0, '0);
    // R5 store hits with varied byte enables, then read back
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 4; w++)
        do_op(1'b1, 1, f, w, 32'hC0DE_0000 + 32'(f * 16 + w) * 32'h0101_0101,
              4'((f * 4 + w) % 15 + 1));
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 4; w++) do_op(1'b0, 1, f, w, '0, '0);
    // R7 conflicts on modified frames
    do_op(1'b0, 2, 0, 3, '0, '0);
    do_op(1'b0, 2, 1, 0, '0, '0);
    // R8 conflict on a clean frame
    do_op(1'b0, 3, 0, 1, '0, '0);
    // R6 store miss on a clean frame, then read back
    do_op(1'b1, 4, 1, 2, 32'hDEAD_BEEF, 4'b0110);
    do_op(1'b0, 4, 1, 2, '0, '0);
    do_op(1'b0, 4, 1, 1, '0, '0);
    // R9 flush with frames 1..3 modified
    do_flush();
    do_op(1'b0, 1, 2, 0, '0, '0);
    do_op(1'b0, 1, 3, 3, '0, '0);
    do_op(1'b0, 5, 2, 1, '0, '0);
    do_op(1'b0, 6, 3, 2, '0, '0);
    do_flush();
    // R10 counters
    chk("R10 hit count", 32'(hit_cnt), 32'(exp_hits));
    chk("R10 miss count", 32'(miss_cnt), 32'(exp_miss));
    finish_up();
  end
endmodule